// File: doc/BRIEF.md
# Streaming Zero-Free Byte Frame Encoder

This block turns byte frames arriving on a ready/valid stream into frames that contain no zero byte, using consistent overhead byte stuffing, and terminates each encoded frame with one 0x00 byte that a receiver can use to find frame boundaries. Input bytes are gathered into segments. Each segment goes out as a code byte followed by its data. The code byte is one more than the number of data bytes in the segment. Because the code byte has to go out ahead of the data it describes, the encoder holds a segment in an internal buffer (up to `SEG_MAX` bytes, 254 by default) until the segment closes.

A segment closes when a zero input byte arrives (the zero is dropped and is implied by the closing), when the buffer fills (code 0xFF, no implied zero), or when the frame ends. While a closed segment is being sent, the input is held off, so the buffer cannot overrun. Both sides honour backpressure fully. A beat whose keep bit is low carries no byte, which lets an upstream source end a frame, or send an empty frame, without adding data.

Top module: `cobs_frame_encoder`

## Requirements
- R1: After synchronous active-low reset, `m_valid` and `m_last` are 0 and `s_ready` is 1. Reset discards any partly gathered segment, so an empty frame sent after the reset encodes to 0x01 0x00.
- R2: A frame of n non-zero bytes (n < 254) encodes as the byte n+1, then the n bytes unchanged, then 0x00.
- R3: A zero input byte in the middle of a frame closes the current segment. The zero byte itself never appears in the output, and the next segment starts with its count reset.
- R4: When 254 non-zero bytes have been gathered, the segment is sent at once as 0xFF followed by those 254 bytes, with no implied zero. Later bytes start a fresh segment.
- R5: If the 254-byte segment of R4 is closed by the frame's last byte, the delimiter follows directly and no extra 0x01 code byte is sent.
- R6: A frame whose last byte is zero ends with an empty segment: code 0x01 is sent just before the delimiter.
- R7: A beat with `s_keep` = 0 adds no byte. A frame made only of such a beat encodes to 0x01 0x00.
- R8: Each encoded frame ends with exactly one 0x00 byte. `m_last` is 1 on that byte only, and `m_user` on that beat equals `s_user` of the input frame's last beat.
- R9: `s_ready` is 0 on every cycle in which `m_valid` is 1. No input is accepted while a segment or the delimiter is being sent.
- R10: Every output byte other than the delimiter is non-zero.
- R11: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_data | input | 8 | Input byte |
| s_keep | input | 1 | Input beat carries a byte |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Encoder accepts the input beat |
| s_last | input | 1 | Last beat of the input frame |
| s_user | input | 1 | Side flag, taken from the frame's last beat |
| m_data | output | 8 | Encoded byte |
| m_valid | output | 1 | Encoded byte valid |
| m_ready | input | 1 | Downstream accepts the encoded byte |
| m_last | output | 1 | Marks the 0x00 delimiter |
| m_user | output | 1 | Side flag on the delimiter beat |

## Verification
A wrong segment count or read pointer appears at the output port within the segment being sent. It shows as a code byte that does not match the number of bytes that follow it, as a zero inside the frame body, or as a delimiter that arrives early or late. A mishandled end-of-frame flag appears one byte before the delimiter, as a missing or surplus 0x01. A gathering path that does not stall shows up as lost input bytes in the next encoded frame. The worst case is a full 254-byte segment, so every such fault is visible within about 256 output beats.

// File: rtl/cobs_enc_pkg.sv
// Shared types for the zero-free frame encoder.
package cobs_enc_pkg;

    // Encoder phase: gather input, send code byte, send body, send delimiter
    typedef enum logic [1:0] {
        ST_TAKE  = 2'd0,
        ST_CODE  = 2'd1,
        ST_BODY  = 2'd2,
        ST_DELIM = 2'd3
    } enc_state_t;

    localparam logic [7:0] FRAME_DELIM = 8'h00;

endpackage

// File: rtl/cobs_seg_buffer.sv
// Segment store: holds the non-zero bytes of the segment being gathered.
// One write port and one asynchronous read port. Assumes the controller
// never writes and reads the same entry in the same cycle (the two phases
// never overlap). Contents are not reset; the controller's fill count
// alone decides which entries are valid.
module cobs_seg_buffer #(
    parameter int DEPTH  = 254,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    // Store an accepted non-zero byte
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the byte being sent
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cobs_enc_ctrl.sv
// Encoder control: counts the open segment, decides when it closes, then
// walks the code byte, the buffered body and the delimiter out of the
// output port. Input is accepted only in the gathering phase, so the output
// side never sees a combinational path from s_valid, and the input side
// never sees one from m_ready.
module cobs_enc_ctrl
    import cobs_enc_pkg::*;
#(
    parameter int SEG_MAX = 254,
    parameter int CNT_W   = 8,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        s_data,
    input  logic              s_keep,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_last,
    input  logic              s_user,
    output logic [7:0]        m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_last,
    output logic              m_user,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);

    enc_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;    // bytes in the open segment
    logic [CNT_W-1:0] rd_q;     // next body byte to send
    logic             pend_q;   // an end-of-frame segment is still owed
    logic             more_q;   // after this segment, another one is owed
    logic             eof_q;    // the frame's last beat has been taken
    logic             user_q;   // side flag of the last beat

    logic take;
    logic nz_byte;
    logic seg_end;

    // Decode the accepted beat and the end of the segment being sent
    always_comb begin
        take    = s_valid && (state_q == ST_TAKE);
        nz_byte = take && s_keep && (s_data != 8'h00);
        seg_end = m_ready &&
                  (((state_q == ST_CODE) && (cnt_q == '0)) ||
                   ((state_q == ST_BODY) && ((rd_q + CNT_W'(1)) == cnt_q)));
    end

    // Phase sequencing, segment count and end-of-frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_TAKE;
            cnt_q   <= '0;
            rd_q    <= '0;
            pend_q  <= 1'b1;
            more_q  <= 1'b0;
            eof_q   <= 1'b0;
            user_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_TAKE: begin
                    if (take) begin
                        if (s_last) begin
                            eof_q  <= 1'b1;
                            user_q <= s_user;
                        end
                        if (nz_byte) begin
                            cnt_q  <= cnt_q + CNT_W'(1);
                            pend_q <= 1'b1;
                            if (cnt_q == CNT_W'(SEG_MAX - 1) || s_last) begin
                                state_q <= ST_CODE;
                                more_q  <= 1'b0;
                            end
                        end else if (s_keep) begin
                            state_q <= ST_CODE;
                            more_q  <= 1'b1;
                        end else if (s_last) begin
                            state_q <= pend_q ? ST_CODE : ST_DELIM;
                            more_q  <= 1'b0;
                        end
                    end
                end
                ST_CODE: begin
                    if (m_ready && cnt_q != '0) begin
                        state_q <= ST_BODY;
                        rd_q    <= '0;
                    end
                end
                ST_BODY: begin
                    if (m_ready) begin
                        rd_q <= rd_q + CNT_W'(1);
                    end
                end
                ST_DELIM: begin
                    if (m_ready) begin
                        state_q <= ST_TAKE;
                        eof_q   <= 1'b0;
                        pend_q  <= 1'b1;
                        user_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_TAKE;
            endcase
            if (seg_end) begin
                cnt_q <= '0;
                rd_q  <= '0;
                if (!eof_q) begin
                    state_q <= ST_TAKE;
                    pend_q  <= more_q;
                end else if (more_q) begin
                    state_q <= ST_CODE;
                    more_q  <= 1'b0;
                end else begin
                    state_q <= ST_DELIM;
                end
            end
        end
    end

    // Output byte selection by phase
    always_comb begin
        case (state_q)
            ST_CODE: m_data = 8'(cnt_q) + 8'd1;
            ST_BODY: m_data = rd_data;
            default: m_data = FRAME_DELIM;
        endcase
    end

    assign s_ready = (state_q == ST_TAKE);
    assign m_valid = (state_q != ST_TAKE);
    assign m_last  = (state_q == ST_DELIM);
    assign m_user  = (state_q == ST_DELIM) && user_q;
    assign wr_en   = nz_byte;
    assign wr_addr = ADDR_W'(cnt_q);
    assign rd_addr = ADDR_W'(rd_q);

endmodule

// File: rtl/cobs_frame_encoder.sv
// Zero-free frame encoder top: a segment store plus its controller.
// Assumes SEG_MAX lies in 1..254 so that every code byte fits in eight bits.
module cobs_frame_encoder #(
    parameter int SEG_MAX = 254
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] s_data,
    input  logic       s_keep,
    input  logic       s_valid,
    output logic       s_ready,
    input  logic       s_last,
    input  logic       s_user,
    output logic [7:0] m_data,
    output logic       m_valid,
    input  logic       m_ready,
    output logic       m_last,
    output logic       m_user
);

    localparam int CNT_W  = $clog2(SEG_MAX + 1);
    localparam int ADDR_W = (SEG_MAX > 1) ? $clog2(SEG_MAX) : 1;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    cobs_seg_buffer #(
        .DEPTH  (SEG_MAX),
        .ADDR_W (ADDR_W)
    ) i_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (s_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cobs_enc_ctrl #(
        .SEG_MAX (SEG_MAX),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_data  (s_data),
        .s_keep  (s_keep),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_last  (s_last),
        .s_user  (s_user),
        .m_data  (m_data),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_last  (m_last),
        .m_user  (m_user),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cobs_enc_checker.sv
// Port-level properties of the frame encoder. Tracks how many body bytes
// the last code byte announced so that segment lengths can be checked.
module cobs_enc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready,
    input logic [7:0] m_data,
    input logic       m_valid,
    input logic       m_ready,
    input logic       m_last
);

    logic [7:0] left_q;

    // Body bytes still owed by the most recent code byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= 8'd0;
        end else if (m_valid && m_ready) begin
            if (left_q != 8'd0) begin
                left_q <= left_q - 8'd1;
            end else if (!m_last) begin
                left_q <= m_data - 8'd1;
            end
        end
    end

    assert_body_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && left_q != 8'd0) |-> !m_last);

    assert_delim_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> (m_data == 8'h00));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready);

    assert_body_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last) |-> (m_data != 8'h00));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

endmodule

bind cobs_frame_encoder cobs_enc_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .m_data  (m_data),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_last  (m_last)
);

// File: tb/test_cobs_frame_encoder.sv
// Bench: directed corner frames plus seeded random frames, each compared
// against a reference encoding computed here.
module test_cobs_frame_encoder;

    localparam int SEGM   = 254;
    localparam int LIMIT  = 8000;

    typedef logic [7:0] bq_t[$];
    typedef bit         kq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_keep = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic       s_last = 1'b0;
    logic       s_user = 1'b0;
    logic [7:0] m_data;
    logic       m_valid;
    logic       m_ready = 1'b0;
    logic       m_last;
    logic       m_user;

    int tests = 0;
    int fails = 0;
    bit abort = 0;

    always #2 clk = ~clk;

    cobs_frame_encoder #(.SEG_MAX(SEGM)) i_cobs_frame_encoder (
        .clk(clk), .rst_n(rst_n),
        .s_data(s_data), .s_keep(s_keep), .s_valid(s_valid), .s_ready(s_ready),
        .s_last(s_last), .s_user(s_user),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
        .m_last(m_last), .m_user(m_user)
    );

    task automatic check(input string req, input bit ok, input string detail);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    // Reference encoding of the kept bytes of one frame
    function automatic bq_t cobs_ref(bq_t d, kq_t k);
        bq_t o;
        bq_t seg;
        int  code = 1;
        bit  open = 1;
        for (int i = 0; i < d.size(); i++) begin
            if (k[i]) begin
                if (d[i] == 8'h00) begin
                    o.push_back(8'(code));
                    foreach (seg[j]) o.push_back(seg[j]);
                    seg.delete();
                    code = 1;
                    open = 1;
                end else begin
                    seg.push_back(d[i]);
                    code++;
                    open = 1;
                    if (code == SEGM + 1) begin
                        o.push_back(8'(code));
                        foreach (seg[j]) o.push_back(seg[j]);
                        seg.delete();
                        code = 1;
                        open = 0;
                    end
                end
            end
        end
        if (open) begin
            o.push_back(8'(code));
            foreach (seg[j]) o.push_back(seg[j]);
        end
        o.push_back(8'h00);
        return o;
    endfunction

    // Send one frame with random gaps and stalls, collect and compare
    task automatic run_frame(input bq_t d, input kq_t k, input bit usr,
                             input int vpct, input int rpct, input string req);
        bq_t        exp;
        bq_t        got;
        int         idx = 0;
        int         cyc = 0;
        int         bad_excl = 0;
        int         bad_hold = 0;
        bit         done = 0;
        bit         stall = 0;
        logic [7:0] pdata = 8'h00;
        bit         guser = 0;
        int         mism = -1;
        if (abort) return;
        exp = cobs_ref(d, k);
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (stall && (!m_valid || m_data != pdata)) bad_hold++;
            if (s_ready && m_valid) bad_excl++;
            if (idx < d.size()) begin
                s_valid = ($urandom_range(99) < vpct);
                s_data  = d[idx];
                s_keep  = k[idx];
                s_last  = (idx == d.size() - 1);
                s_user  = s_last ? usr : 1'($urandom_range(1));
            end else begin
                s_valid = 1'b0;
                s_last  = 1'b0;
            end
            m_ready = ($urandom_range(99) < rpct);
            if (s_valid && s_ready) idx++;
            if (m_valid && m_ready) begin
                got.push_back(m_data);
                if (m_last) begin
                    done  = 1;
                    guser = m_user;
                end
            end
            stall = m_valid && !m_ready;
            pdata = m_data;
        end
        @(negedge clk);
        s_valid = 1'b0;
        m_ready = 1'b0;
        if (!done) begin
            abort = 1;
            check("watchdog", 0, $sformatf("no delimiter after %0d cycles, got %0d bytes, expected %0d",
                                            LIMIT, got.size(), exp.size()));
            return;
        end
        for (int i = 0; i < exp.size(); i++) begin
            if (mism < 0 && (i >= got.size() || got[i] != exp[i])) mism = i;
        end
        if (got.size() != exp.size() && mism < 0) mism = exp.size();
        check(req, mism < 0 && idx == d.size(),
              $sformatf("len %0d exp %0d, first diff at %0d: actual %02h expected %02h, consumed %0d of %0d",
                        got.size(), exp.size(), mism,
                        (mism >= 0 && mism < got.size()) ? got[mism] : 8'hxx,
                        (mism >= 0 && mism < exp.size()) ? exp[mism] : 8'hxx,
                        idx, d.size()));
        check("R8", guser == usr, $sformatf("m_user actual %0b expected %0b", guser, usr));
        check("R9", bad_excl == 0, $sformatf("s_ready high with m_valid on %0d cycles, expected 0", bad_excl));
        if (rpct < 100)
            check("R11", bad_hold == 0, $sformatf("output changed under stall %0d times, expected 0", bad_hold));
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        s_valid = 1'b0;
        m_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        bq_t d;
        kq_t k;
        void'($urandom(32'd20251));
        do_reset();
        check("R1", !m_valid && !m_last && s_ready,
              $sformatf("after reset m_valid=%0b m_last=%0b s_ready=%0b, expected 0 0 1", m_valid, m_last, s_ready));

        // R2: short non-zero frame
        d = '{8'h11, 8'h22, 8'h33}; k = '{1, 1, 1};
        run_frame(d, k, 1'b1, 100, 100, "R2");
        // R3: zero in the middle
        d = '{8'h11, 8'h00, 8'h22}; k = '{1, 1, 1};
        run_frame(d, k, 1'b0, 100, 60, "R3");
        // R6: frame of one zero byte
        d = '{8'h00}; k = '{1};
        run_frame(d, k, 1'b1, 100, 100, "R6");
        // R5: exactly one full segment ending the frame
        d.delete(); k.delete();
        for (int i = 0; i < 254; i++) begin d.push_back(8'((i % 255) + 1)); k.push_back(1); end
        run_frame(d, k, 1'b0, 80, 70, "R5");
        // R4: full segment followed by more data
        d.delete(); k.delete();
        for (int i = 0; i < 300; i++) begin d.push_back(8'((i % 250) + 3)); k.push_back(1); end
        run_frame(d, k, 1'b1, 90, 50, "R4");
        // R6: full segment then a zero as the last byte
        d.delete(); k.delete();
        for (int i = 0; i < 254; i++) begin d.push_back(8'h5A); k.push_back(1); end
        d.push_back(8'h00); k.push_back(1);
        run_frame(d, k, 1'b1, 100, 100, "R6");
        // R7: empty frame
        d = '{8'h77}; k = '{0};
        run_frame(d, k, 1'b1, 100, 100, "R7");
        // R7: empty beats mid frame and as the last beat
        d = '{8'h05, 8'h00, 8'h06, 8'h99}; k = '{1, 0, 1, 0};
        run_frame(d, k, 1'b0, 70, 70, "R7");

        // R1: reset mid-gathering discards the partial segment
        if (!abort) begin
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                s_valid = 1'b1; s_keep = 1'b1; s_last = 1'b0; s_data = 8'(i + 1);
            end
            @(negedge clk);
            s_valid = 1'b0;
            do_reset();
            d = '{8'h00}; k = '{0};
            run_frame(d, k, 1'b0, 100, 100, "R1");
        end

        // R2/R3/R4/R7 mixed: seeded random frames
        for (int f = 0; f < 18; f++) begin
            int len  = $urandom_range(400, 1);
            int zpct = (f % 3 == 0) ? 0 : ((f % 3 == 1) ? 5 : 50);
            d.delete(); k.delete();
            for (int i = 0; i < len; i++) begin
                d.push_back(($urandom_range(99) < zpct) ? 8'h00 : 8'($urandom_range(255, 1)));
                k.push_back($urandom_range(99) >= 5);
            end
            run_frame(d, k, 1'($urandom_range(1)), $urandom_range(100, 30), $urandom_range(100, 30), "R2");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule